// File: doc/BRIEF.md
# LDPC Early Termination Controller

This block decides when an iterative LDPC decoder should stop working on the current codeword. After every decoding iteration the decoder presents one parity bit per check node, with 384 check nodes by default. Each bit is the XOR of the hard-decision signs of the variable nodes attached to that check. The controller counts the failing checks, called the syndrome weight, and compares that count against a small set of rules. It then either lets decoding continue or ends it with a one-cycle completion pulse.

There are three ways to finish. A syndrome weight of zero at any iteration is a clean finish: the decoder holds a valid codeword. A codeword that is unlikely to converge is abandoned at a second checkpoint iteration. This happens only if its weight was above a first limit at an earlier checkpoint iteration and is still above a second limit at the second checkpoint. Both limits are fixed and do not depend on channel SNR. Any codeword that neither converges nor is abandoned runs until the iteration budget is used up. The outcome flags and the number of iterations used stay readable until the next codeword is announced with `start`.

Top module: `ldpc_stop_ctrl`

## Requirements
- R1: After reset, `done`, `success` and `abort` are 0, `iter_used` is 0, and `chk_valid` is ignored until the first `start`.
- R2: A `start` pulse clears `success`, `abort`, `iter_used` and the remembered checkpoint flag. On the next clock edge the controller accepts iterations again. `start` takes precedence over a `chk_valid` in the same cycle.
- R3: The syndrome weight is the number of 1 bits in `chk_bits`, and iterations are numbered from 1 after `start`. When the weight of an accepted iteration is zero, `done` pulses one cycle after that `chk_valid`, with `success`=1, `abort`=0 and `iter_used` equal to that iteration's number.
- R4: At iteration `CKPT_A` (default 3) the controller records whether the weight is strictly greater than `LIM_A` (default 134).
- R5: At iteration `CKPT_B` (default 6), if the weight is strictly greater than `LIM_B` (default 134) and the flag recorded at `CKPT_A` is set, `done` pulses with `abort`=1, `success`=0 and `iter_used`=`CKPT_B`.
- R6: If only one of the two checkpoint tests is exceeded, decoding does not stop at `CKPT_B` and continues to later iterations.
- R7: If iteration `MAX_ITER` (default 15) has a nonzero weight and no abort applies, `done` pulses with `success`=0, `abort`=0 and `iter_used`=`MAX_ITER`. `iter_used` never exceeds `MAX_ITER`.
- R8: After `done`, further `chk_valid` pulses before the next `start` have no effect: `done` stays low and `success`, `abort` and `iter_used` keep their values.
- R9: `done` is high for exactly one cycle per codeword. `success`, `abort` and `iter_used` change only on an accepted iteration or on `start`.
- R10: Both limit tests are strict. A weight exactly equal to a limit does not count as exceeding it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | New codeword begins; clears the iteration state |
| chk_valid | input | 1 | End of one decoding iteration; `chk_bits` is valid |
| chk_bits | input | NCHK | One parity result per check node, 1 = unsatisfied |
| done | output | 1 | One-cycle pulse when decoding of the codeword ends |
| success | output | 1 | Held high after a finish with zero syndrome weight |
| abort | output | 1 | Held high after a threshold-based abandonment |
| iter_used | output | $clog2(MAX_ITER+1) | Number of iterations accepted for the current codeword |

## Verification
The bench uses syndrome weights placed right on the limits. It shows that a weight equal to a limit never triggers an abort, which a design using `>=` would get wrong by stopping too early at the second checkpoint. It runs codewords in which only the first test fires and codewords in which only the second fires. A controller that tested either condition alone would abandon these at iteration 6 instead of running on to convergence or to the iteration budget. It reuses the controller for a second codeword after a first one that set the checkpoint flag. A flag left over from the earlier codeword would cause a false abort. It also feeds `chk_valid` pulses after completion. A design that kept counting after `done` would pulse again or corrupt the held result.

// File: rtl/ldpc_stop_pkg.sv
package ldpc_stop_pkg;

  typedef enum logic [1:0] {
    VERDICT_GO    = 2'd0,
    VERDICT_CLEAN = 2'd1,
    VERDICT_GIVEUP = 2'd2,
    VERDICT_BUDGET = 2'd3
  } verdict_e;

  // strict comparison used by both checkpoint tests
  function automatic logic above_limit(input int unsigned weight, input int unsigned limit);
    return weight > limit;
  endfunction

  // abandon rule: both checkpoint tests exceeded
  function automatic logic give_up(input logic early_flag, input logic late_over);
    return early_flag && late_over;
  endfunction

endpackage

// File: rtl/ldpc_syndrome_count.sv
module ldpc_syndrome_count #(
  parameter int NCHK = 384,
  parameter int GRP  = 32,
  localparam int NGRP = (NCHK + GRP - 1) / GRP,
  localparam int GW   = $clog2(GRP + 1),
  localparam int SW   = $clog2(NCHK + 1)
) (
  input  logic [NCHK-1:0] bits,
  output logic [SW-1:0]   weight
);

  logic [NGRP*GRP-1:0] padded;
  logic [GW-1:0]       part [NGRP];

  assign padded = {{(NGRP*GRP-NCHK){1'b0}}, bits};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      part[g] = '0;
      for (int b = 0; b < GRP; b++) begin
        part[g] = part[g] + GW'(padded[g*GRP+b]);
      end
    end
  end

  always_comb begin
    weight = '0;
    for (int g = 0; g < NGRP; g++) begin
      weight = weight + SW'(part[g]);
    end
  end

endmodule

// File: rtl/ldpc_stop_decide.sv
module ldpc_stop_decide
  import ldpc_stop_pkg::*;
#(
  parameter int SW       = 9,
  parameter int IW       = 4,
  parameter int CKPT_A   = 3,
  parameter int CKPT_B   = 6,
  parameter int LIM_A    = 134,
  parameter int LIM_B    = 134,
  parameter int MAX_ITER = 15
) (
  input  logic [SW-1:0] weight,
  input  logic [IW-1:0] iter_num,
  input  logic          early_flag,
  output logic          at_ckpt_a,
  output logic          flag_value,
  output verdict_e      verdict
);

  logic at_ckpt_b;
  logic at_budget;
  logic late_over;

  assign at_ckpt_a  = (iter_num == IW'(CKPT_A));
  assign at_ckpt_b  = (iter_num == IW'(CKPT_B));
  assign at_budget  = (iter_num == IW'(MAX_ITER));
  assign flag_value = above_limit(int'(weight), LIM_A);
  assign late_over  = above_limit(int'(weight), LIM_B);

  always_comb begin
    if (weight == '0)
      verdict = VERDICT_CLEAN;
    else if (at_ckpt_b && give_up(early_flag, late_over))
      verdict = VERDICT_GIVEUP;
    else if (at_budget)
      verdict = VERDICT_BUDGET;
    else
      verdict = VERDICT_GO;
  end

endmodule

// File: rtl/ldpc_stop_ctrl.sv
module ldpc_stop_ctrl
  import ldpc_stop_pkg::*;
#(
  parameter int NCHK     = 384,
  parameter int CKPT_A   = 3,
  parameter int CKPT_B   = 6,
  parameter int LIM_A    = 134,
  parameter int LIM_B    = 134,
  parameter int MAX_ITER = 15,
  localparam int SW = $clog2(NCHK + 1),
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            chk_valid,
  input  logic [NCHK-1:0] chk_bits,
  output logic            done,
  output logic            success,
  output logic            abort,
  output logic [IW-1:0]   iter_used
);

  logic [SW-1:0] weight_w;
  logic [IW-1:0] iter_q;
  logic [IW-1:0] iter_next_w;
  logic          active_q;
  logic          flag_q;
  logic          done_q;
  logic          pass_q;
  logic          abort_q;
  logic          accept_w;
  logic          at_ckpt_a_w;
  logic          flag_value_w;
  verdict_e      verdict_w;

  assign accept_w    = chk_valid && active_q && !start;
  assign iter_next_w = iter_q + IW'(1);

  ldpc_syndrome_count #(.NCHK(NCHK)) u_count (
    .bits   (chk_bits),
    .weight (weight_w)
  );

  ldpc_stop_decide #(
    .SW(SW), .IW(IW), .CKPT_A(CKPT_A), .CKPT_B(CKPT_B),
    .LIM_A(LIM_A), .LIM_B(LIM_B), .MAX_ITER(MAX_ITER)
  ) u_decide (
    .weight     (weight_w),
    .iter_num   (iter_next_w),
    .early_flag (flag_q),
    .at_ckpt_a  (at_ckpt_a_w),
    .flag_value (flag_value_w),
    .verdict    (verdict_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      iter_q   <= '0;
      flag_q   <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        iter_q   <= '0;
        flag_q   <= 1'b0;
        pass_q   <= 1'b0;
        abort_q  <= 1'b0;
      end else if (accept_w) begin
        iter_q <= iter_next_w;
        if (at_ckpt_a_w) flag_q <= flag_value_w;
        unique case (verdict_w)
          VERDICT_CLEAN: begin
            done_q   <= 1'b1;
            pass_q   <= 1'b1;
            active_q <= 1'b0;
          end
          VERDICT_GIVEUP: begin
            done_q   <= 1'b1;
            abort_q  <= 1'b1;
            active_q <= 1'b0;
          end
          VERDICT_BUDGET: begin
            done_q   <= 1'b1;
            active_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign done      = done_q;
  assign success   = pass_q;
  assign abort     = abort_q;
  assign iter_used = iter_q;

endmodule

// File: rtl/ldpc_stop_ctrl_chk.sv
module ldpc_stop_ctrl_chk #(
  parameter int IW       = 4,
  parameter int CKPT_B   = 6,
  parameter int MAX_ITER = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          chk_valid,
  input logic          accept,
  input logic          active,
  input logic          done,
  input logic          success,
  input logic          abort,
  input logic [IW-1:0] iter_used
);

  // R9
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept));

  // R5
  abort_only_at_ckpt_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && abort) |-> (iter_used == IW'(CKPT_B)));

  // R5
  outcome_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(success && abort));

  // R7
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_used <= IW'(MAX_ITER));

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !success && !abort && iter_used == '0));

  // R8
  idle_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !active && !start) |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !accept) |=> ($stable(success) && $stable(abort) && $stable(iter_used)));

endmodule

bind ldpc_stop_ctrl ldpc_stop_ctrl_chk #(
  .IW(IW), .CKPT_B(CKPT_B), .MAX_ITER(MAX_ITER)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .chk_valid (chk_valid),
  .accept    (accept_w),
  .active    (active_q),
  .done      (done),
  .success   (success),
  .abort     (abort),
  .iter_used (iter_used)
);

// File: tb/ldpc_stop_ctrl_bench.sv
module ldpc_stop_ctrl_bench;

  localparam int NCHK = 384;
  localparam int CA   = 3;
  localparam int CB   = 6;
  localparam int LA   = 134;
  localparam int LB   = 134;
  localparam int MAXI = 15;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            chk_valid = 1'b0;
  logic [NCHK-1:0] chk_bits = '0;
  logic            done;
  logic            success;
  logic            abort;
  logic [3:0]      iter_used;

  int checks = 0;
  int failures = 0;

  // bench-side model of the outcome
  int m_iter = 0;
  bit m_flag = 0;
  bit m_active = 0;
  bit m_pass = 0;
  bit m_abort = 0;

  always #4 clk = ~clk;

  ldpc_stop_ctrl u_ldpc_stop_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .chk_valid(chk_valid),
    .chk_bits(chk_bits), .done(done), .success(success), .abort(abort),
    .iter_used(iter_used)
  );

  function automatic logic [NCHK-1:0] spread(int k);
    logic [NCHK-1:0] v = '0;
    for (int i = 0; i < k; i++) v[(i * 7) % NCHK] = 1'b1;
    return v;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic new_block(string req);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_iter = 0; m_flag = 0; m_active = 1; m_pass = 0; m_abort = 0;
    check(req, "success after start", int'(success), 0);
    check(req, "abort after start", int'(abort), 0);
    check(req, "iter_used after start", int'(iter_used), 0);
  endtask

  // one iteration with syndrome weight s; model predicts, then compare
  task automatic step(int s, string req);
    bit e_done = 0;
    if (m_active) begin
      m_iter++;
      if (s == 0) begin
        e_done = 1; m_pass = 1;
      end else if (m_iter == CB && m_flag && s > LB) begin
        e_done = 1; m_abort = 1;
      end else if (m_iter == MAXI) begin
        e_done = 1;
      end
      if (m_iter == CA) m_flag = (s > LA);
      if (e_done) m_active = 0;
    end
    @(negedge clk);
    chk_valid = 1'b1;
    chk_bits  = spread(s);
    @(negedge clk);
    chk_valid = 1'b0;
    chk_bits  = '0;
    check(req, "done", int'(done), int'(e_done));
    check(req, "success", int'(success), int'(m_pass));
    check(req, "abort", int'(abort), int'(m_abort));
    check(req, "iter_used", int'(iter_used), m_iter);
    if (e_done) begin
      @(negedge clk);
      check("R9", "done pulse width", int'(done), 0);
      check("R9", "success held", int'(success), int'(m_pass));
    end
  endtask

  task automatic t_reset();
    check("R1", "done at reset", int'(done), 0);
    check("R1", "success at reset", int'(success), 0);
    check("R1", "abort at reset", int'(abort), 0);
    check("R1", "iter_used at reset", int'(iter_used), 0);
    step(0, "R1");
  endtask

  task automatic t_clean();
    new_block("R2");
    step(50, "R3");
    step(0, "R3");
    check("R3", "clean finish iteration", int'(iter_used), 2);
    new_block("R3");
    step(0, "R3");
  endtask

  task automatic t_giveup();
    new_block("R2");
    for (int i = 1; i <= 6; i++) step(200, "R5");
    check("R5", "abort at second checkpoint", int'(abort), 1);
    check("R5", "abort iteration", int'(iter_used), CB);
    step(0, "R8");
    step(300, "R8");
    check("R8", "abort held after idle valid", int'(abort), 1);
  endtask

  task automatic t_only_first();
    new_block("R2");
    for (int i = 1; i <= 5; i++) step(200, "R6");
    step(100, "R6");
    check("R6", "no stop when only first exceeded", int'(abort), 0);
    for (int i = 7; i <= 15; i++) step(100, "R7");
    check("R7", "budget iteration", int'(iter_used), MAXI);
    check("R7", "budget success", int'(success), 0);
  endtask

  task automatic t_only_second();
    new_block("R2");
    step(90, "R6"); step(90, "R6"); step(100, "R6");
    step(200, "R6"); step(200, "R6"); step(250, "R6");
    step(120, "R6");
    step(0, "R6");
    check("R6", "converges after checkpoint", int'(iter_used), 8);
  endtask

  task automatic t_equal_limits();
    new_block("R2");
    step(200, "R10"); step(200, "R10"); step(134, "R10");
    step(200, "R10"); step(200, "R10"); step(200, "R10");
    check("R10", "first limit equal no abort", int'(abort), 0);
    step(0, "R10");
    new_block("R2");
    step(200, "R10"); step(200, "R10"); step(135, "R10");
    step(200, "R10"); step(200, "R10"); step(134, "R10");
    check("R10", "second limit equal no abort", int'(abort), 0);
    step(0, "R10");
  endtask

  task automatic t_flag_cleared();
    new_block("R2");
    step(200, "R4"); step(200, "R4"); step(384, "R4");
    step(0, "R4");
    new_block("R2");
    step(10, "R2"); step(10, "R2"); step(10, "R2");
    step(10, "R2"); step(10, "R2"); step(200, "R2");
    check("R2", "stale flag must not abort", int'(abort), 0);
    step(0, "R2");
  endtask

  task automatic t_start_priority();
    new_block("R2");
    step(5, "R2");
    @(negedge clk);
    start = 1'b1; chk_valid = 1'b1; chk_bits = '0;
    @(negedge clk);
    start = 1'b0; chk_valid = 1'b0;
    check("R2", "start beats valid: done", int'(done), 0);
    check("R2", "start beats valid: iter", int'(iter_used), 0);
    m_iter = 0; m_flag = 0; m_active = 1; m_pass = 0; m_abort = 0;
    step(0, "R2");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_giveup();
    t_only_first();
    t_only_second();
    t_equal_limits();
    t_flag_cleared();
    t_start_priority();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule